// File: doc/BRIEF.md
# Host-to-Memory Indirect Access Port

This block gives a 16-bit host a narrow window into two on-chip memories: a 24-bit wide program memory and a 16-bit wide data memory. The host sees only two locations. The first is a pointer register that holds a 14-bit word address and a space select bit. The second is a data window. A write to the window sends a value toward memory, and a read from it returns a value from memory. After each completed word transfer the pointer advances by itself. A block of words can therefore be streamed after a single pointer write.

A 24-bit program word does not fit in one host access, so it is moved in two halves. The upper half (word bits 23:8) goes first and the lower byte (bits 7:0) second. The pointer advances only after the lower byte. On a write, the upper half waits in a holding register, and the whole word is committed in one memory write. On a read, the whole word is fetched by the first access and its lower byte is kept for the second. A pointer write between the two halves drops the unfinished word and restarts the sequence at the new address.

Each transfer that touches memory takes exactly one memory cycle, which is won from the memory owner with a request/grant handshake. Host requests use valid/ready: a request is taken on a cycle where both `host_valid` and `host_ready` are high. `host_ready` falls only while a memory cycle is outstanding. Read results come back as a one-cycle `rsp_valid` pulse with no back-pressure, so the host must take them when they appear.

Top module: `idma_port`

## Requirements
- R1: A control access (`host_sel`=0) writes the pointer: bits 13:0 are the address and bit 14 is the space select (1 = data memory, 0 = program memory). A control read returns {1'b0, select, address} on `rsp_data` with `rsp_valid` high in the cycle after acceptance.
- R2: A data-window write while the data space is selected makes one memory write of {8'h00, host word} at the current address. The address then steps by one.
- R3: A data-window read while the data space is selected makes one memory read. `rsp_valid` is high in the cycle after the grant, with `mem_rdata[15:0]` on `rsp_data`. The address then steps by one.
- R4: With the program space selected, the first data-window write after a pointer write, and every odd-numbered one after it, is only held: no memory cycle and no address step. The next (even-numbered) write makes one memory write of {held word, host bits 7:0}, so host bits 15:8 are ignored. The address then steps by one.
- R5: With the program space selected, an odd-numbered window read fetches the word and returns bits 23:8 without stepping the address. The following read makes no memory cycle, returns {8'h00, bits 7:0} in the cycle after acceptance, and steps the address.
- R6: A pointer write made between the two halves of a program word discards the pending lower half. The next window access is again an upper-half access, at the new address.
- R7: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle in which `mem_gnt` is high, and then falls. While `mem_req` is high, `host_ready` is low.
- R8: The address steps from 0x3FFF to 0x0000.
- R9: After reset the address is 0, the program space is selected, the sequence is at the upper half, and `mem_req` and `rsp_valid` are low.
- R10: Accesses that need no memory cycle (control accesses, upper-half program writes, lower-half program reads) leave `host_ready` high, so they can follow one another in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Port can take a host request |
| host_sel | input | 1 | 0 = control (pointer) location, 1 = data window |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 16 | Host write data |
| rsp_valid | output | 1 | One-cycle pulse: read result present |
| rsp_data | output | 16 | Read result |
| mem_req | output | 1 | Memory cycle request, held until granted |
| mem_gnt | input | 1 | Memory cycle grant |
| mem_addr | output | 14 | Memory word address |
| mem_dsel | output | 1 | 1 = data memory, 0 = program memory |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, valid while granted |

## Verification
The port is driven with program-space write pairs whose upper host byte on the second write is nonzero, which catches any leak of the ignored byte into the committed word, and with read pairs over a memory model whose returned words encode their own address, which catches a wrong half, an early fetch or a missing address step. Data-space reads and writes confirm the single-access path and the advance after each one. A pointer write inserted between two halves shows whether the pending lower half is really dropped. A delayed grant shows whether the request and its fields are held. A pointer at 0x3FFF shows the wrap, and a second reset in the middle of the run confirms the reset state.

// File: rtl/idma_pkg.sv
package idma_pkg;
  typedef enum logic {PH_MS = 1'b0, PH_LS = 1'b1} phase_e;
endpackage

// File: rtl/idma_addr_ctr.sv
module idma_addr_ctr
  import idma_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_dsel,
  input  logic              adv,
  input  logic              to_ls,
  output logic [ADDR_W-1:0] addr,
  output logic              dsel,
  output logic              phase_ls
);
  phase_e ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      dsel <= 1'b0;
      ph   <= PH_MS;
    end else if (load) begin
      addr <= load_addr;
      dsel <= load_dsel;
      ph   <= PH_MS;
    end else if (adv) begin
      addr <= addr + 1'b1;
      ph   <= PH_MS;
    end else if (to_ls) begin
      ph   <= PH_LS;
    end
  end

  assign phase_ls = (ph == PH_LS);

  // R8: counter wraps at the top of the address space
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && addr == {ADDR_W{1'b1}}) |=> (addr == '0));

  // R2: each completed transfer moves the address by exactly one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  // R6: a pointer write restarts the half-word sequence at the new address
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> (!phase_ls && addr == $past(load_addr)));
endmodule

// File: rtl/idma_mem_port.sv
module idma_mem_port #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic [WORD_W-1:0] start_wdata,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else if (start) begin
      mem_req   <= 1'b1;
      mem_we    <= start_we;
      mem_wdata <= start_wdata;
    end else if (mem_req && mem_gnt) begin
      mem_req   <= 1'b0;
    end
  end

  assign done = mem_req && mem_gnt;

  // R7: an ungranted request holds with its fields stable
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));

  // R7: request only drops after a grant
  p_req_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_req) |-> $past(mem_gnt));

  // R7: no new transfer is launched over an outstanding one
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !start);
endmodule

// File: rtl/idma_port.sv
module idma_port
  import idma_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int HOST_W = 16,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              rsp_valid,
  output logic [HOST_W-1:0] rsp_data,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_dsel,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int LS_W  = WORD_W - HOST_W;
  localparam int PAD_C = HOST_W - ADDR_W - 1;

  logic              acc, ctrl_wr, ctrl_rd, dat_wr, dat_rd;
  logic [ADDR_W-1:0] addr;
  logic              dsel, phase_ls;
  logic              ms_wr, ls_rd, start, done, adv, to_ls, ms_rd_done;
  logic [HOST_W-1:0] ms_buf;
  logic [LS_W-1:0]   ls_hold;
  logic [WORD_W-1:0] start_wdata;

  assign host_ready = !mem_req;
  assign acc        = host_valid && host_ready;
  assign ctrl_wr    = acc && !host_sel && host_we;
  assign ctrl_rd    = acc && !host_sel && !host_we;
  assign dat_wr     = acc && host_sel && host_we;
  assign dat_rd     = acc && host_sel && !host_we;

  // program-space half handling
  assign ms_wr = dat_wr && !dsel && !phase_ls;
  assign ls_rd = dat_rd && !dsel && phase_ls;
  assign start = (dat_wr && (dsel || phase_ls)) || (dat_rd && (dsel || !phase_ls));

  assign start_wdata = dsel ? {{LS_W{1'b0}}, host_wdata}
                            : {ms_buf, host_wdata[LS_W-1:0]};

  assign ms_rd_done = done && !mem_we && !dsel;
  assign adv   = (done && (mem_we || dsel)) || ls_rd;
  assign to_ls = ms_wr || ms_rd_done;

  idma_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (ctrl_wr),
    .load_addr (host_wdata[ADDR_W-1:0]),
    .load_dsel (host_wdata[ADDR_W]),
    .adv       (adv),
    .to_ls     (to_ls),
    .addr      (addr),
    .dsel      (dsel),
    .phase_ls  (phase_ls)
  );

  idma_mem_port #(.WORD_W(WORD_W)) u_mem (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_we    (host_we),
    .start_wdata (start_wdata),
    .mem_gnt     (mem_gnt),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .done        (done)
  );

  assign mem_addr = addr;
  assign mem_dsel = dsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_buf  <= '0;
      ls_hold <= '0;
    end else begin
      if (ms_wr)      ms_buf  <= host_wdata;
      if (ms_rd_done) ls_hold <= mem_rdata[LS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (ctrl_rd) begin
        rsp_valid <= 1'b1;
        rsp_data  <= {{PAD_C{1'b0}}, dsel, addr};
      end else if (ls_rd) begin
        rsp_valid <= 1'b1;
        rsp_data  <= {{(HOST_W-LS_W){1'b0}}, ls_hold};
      end else if (done && !mem_we) begin
        rsp_valid <= 1'b1;
        rsp_data  <= dsel ? mem_rdata[HOST_W-1:0] : mem_rdata[WORD_W-1:LS_W];
      end
    end
  end

  // R5: lower-half program read is served without a memory cycle
  p_ls_rd_local_r5: assert property (@(posedge clk) disable iff (rst)
    ls_rd |=> (!mem_req && rsp_valid));

  // R4: upper-half program write is only held
  p_ms_wr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ms_wr |=> !mem_req);

  // R3: a granted memory read answers in the next cycle
  p_rd_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && !mem_we) |=> rsp_valid);

  // R10: accesses needing no memory cycle keep the port ready
  p_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (acc && !start) |=> host_ready);
endmodule

// File: tb/idma_port_tb.sv
module idma_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0, host_sel = 1'b0, host_we = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic        mem_req, mem_gnt, mem_dsel, mem_we;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  int total = 0, bad = 0, gnt_delay = 0, wcnt = 0, cycles = 0, wr_cnt = 0;
  logic [23:0] last_wdata;
  logic [13:0] last_waddr;
  bit finished = 0;

  always #5 clk = ~clk;

  idma_port u_dut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_sel(host_sel), .host_we(host_we), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_dsel(mem_dsel),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: word encodes its own address
  assign mem_rdata = mem_dsel ? {10'h003, mem_addr} : {10'h270, mem_addr};
  assign mem_gnt   = mem_req && (wcnt >= gnt_delay);

  always @(posedge clk) begin
    if (rst || !mem_req || mem_gnt) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (!rst && mem_req && mem_gnt) begin
      cycles <= cycles + 1;
      if (mem_we) begin
        wr_cnt     <= wr_cnt + 1;
        last_wdata <= mem_wdata;
        last_waddr <= mem_addr;
      end
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic sel, input logic we, input logic [15:0] d,
                        output logic [15:0] rd);
    @(negedge clk);
    host_valid = 1'b1; host_sel = sel; host_we = we; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    rd = '0;
    if (!we) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_data;
    end
    while (mem_req) @(negedge clk);
  endtask

  // {req[3:0], op[2:0], wdata[15:0], exp[23:0], eaddr[13:0]}
  // op: 0 ctrl wr, 1 ctrl rd, 2 data wr w/ mem, 3 data rd, 4 data wr held, 5 data rd local
  localparam logic [60:0] VEC [22] = '{
    {4'd1, 3'd0, 16'h0010, 24'h0, 14'h0},      // R1 pointer to program 0x10
    {4'd1, 3'd1, 16'h0000, 24'h000010, 14'h0}, // R1
    {4'd4, 3'd4, 16'hABCD, 24'h0, 14'h0},      // R4 upper half held
    {4'd4, 3'd1, 16'h0000, 24'h000010, 14'h0}, // R4 no step yet
    {4'd4, 3'd2, 16'h77EF, 24'hABCDEF, 14'h0010}, // R4 bits 15:8 ignored
    {4'd4, 3'd1, 16'h0000, 24'h000011, 14'h0}, // R4 step after lower
    {4'd5, 3'd0, 16'h0012, 24'h0, 14'h0},      // R5
    {4'd5, 3'd3, 16'h0000, 24'h009C00, 14'h0}, // R5 upper half
    {4'd5, 3'd1, 16'h0000, 24'h000012, 14'h0}, // R5 no step
    {4'd5, 3'd5, 16'h0000, 24'h000012, 14'h0}, // R5 lower byte
    {4'd5, 3'd1, 16'h0000, 24'h000013, 14'h0}, // R5 stepped
    {4'd1, 3'd0, 16'h4200, 24'h0, 14'h0},      // R1 data space 0x200
    {4'd1, 3'd1, 16'h0000, 24'h004200, 14'h0}, // R1
    {4'd2, 3'd2, 16'h1234, 24'h001234, 14'h0200}, // R2
    {4'd3, 3'd3, 16'h0000, 24'h00C201, 14'h0}, // R3
    {4'd3, 3'd1, 16'h0000, 24'h004202, 14'h0}, // R3
    {4'd6, 3'd0, 16'h0105, 24'h0, 14'h0},      // R6
    {4'd6, 3'd4, 16'h5555, 24'h0, 14'h0},      // R6 upper pending
    {4'd6, 3'd0, 16'h0106, 24'h0, 14'h0},      // R6 pointer write abandons
    {4'd6, 3'd4, 16'h1111, 24'h0, 14'h0},      // R6 upper again
    {4'd6, 3'd2, 16'hFF22, 24'h111122, 14'h0106}, // R6
    {4'd6, 3'd1, 16'h0000, 24'h000107, 14'h0}  // R6
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int c0, w0, reqc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9 reset state
    chk("R9 mem_req", {23'b0, mem_req}, 24'h0);
    chk("R9 rsp_valid", {23'b0, rsp_valid}, 24'h0);
    chk("R9 host_ready", {23'b0, host_ready}, 24'h1);
    access(1'b0, 1'b0, 16'h0, rd);
    chk("R9 pointer", {8'h0, rd}, 24'h0);

    for (int i = 0; i < 22; i++) begin
      logic [3:0]  rq;
      logic [2:0]  op;
      logic [15:0] wd;
      logic [23:0] ex;
      logic [13:0] ea;
      string tag;
      {rq, op, wd, ex, ea} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      c0 = cycles; w0 = wr_cnt;
      case (op)
        3'd0: access(1'b0, 1'b1, wd, rd);
        3'd1: begin access(1'b0, 1'b0, wd, rd); chk(tag, {8'h0, rd}, ex); end
        3'd2: begin
          access(1'b1, 1'b1, wd, rd);
          chk(tag, 24'(wr_cnt - w0), 24'd1);
          chk(tag, last_wdata, ex);
          chk(tag, {10'h0, last_waddr}, {10'h0, ea});
        end
        3'd3: begin access(1'b1, 1'b0, wd, rd); chk(tag, {8'h0, rd}, ex); end
        3'd4: begin access(1'b1, 1'b1, wd, rd); chk(tag, 24'(cycles - c0), 24'd0); end
        default: begin
          access(1'b1, 1'b0, wd, rd);
          chk(tag, {8'h0, rd}, ex);
          chk(tag, 24'(cycles - c0), 24'd0);
        end
      endcase
    end

    // R8 wrap in data space
    access(1'b0, 1'b1, 16'h7FFF, rd);
    access(1'b1, 1'b0, 16'h0, rd);
    chk("R8 read at 0x3FFF", {8'h0, rd}, 24'h00FFFF);
    access(1'b0, 1'b0, 16'h0, rd);
    chk("R8 wrapped pointer", {8'h0, rd}, 24'h004000);

    // R7 held request under delayed grant
    access(1'b0, 1'b1, 16'h4020, rd);
    gnt_delay = 3;
    w0 = wr_cnt;
    @(negedge clk);
    host_valid = 1'b1; host_sel = 1'b1; host_we = 1'b1; host_wdata = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    reqc = 0;
    while (mem_req) begin
      reqc++;
      chk("R7 ready low", {23'b0, host_ready}, 24'h0);
      chk("R7 addr held", {10'h0, mem_addr}, 24'h000020);
      chk("R7 data held", mem_wdata, 24'h00BEEF);
      @(negedge clk);
    end
    chk("R7 request cycles", 24'(reqc), 24'd4);
    chk("R7 one write", 24'(wr_cnt - w0), 24'd1);
    gnt_delay = 0;

    // R10 back-to-back local accesses
    access(1'b0, 1'b1, 16'h0030, rd);
    @(negedge clk);
    host_valid = 1'b1; host_sel = 1'b1; host_we = 1'b1; host_wdata = 16'h0102;
    @(posedge clk);
    @(negedge clk);
    chk("R10 ready after held write", {23'b0, host_ready}, 24'h1);
    host_sel = 1'b0; host_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    chk("R10 pointer read in next cycle", {7'b0, rsp_valid, rsp_data}, 24'h010030);

    // R9 reset mid-run
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    access(1'b0, 1'b0, 16'h0, rd);
    chk("R9 pointer after reset", {8'h0, rd}, 24'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule